// File: doc/BRIEF.md
# Priority Interrupt Controller with Call-Vector Acknowledge

This block collects eight interrupt request lines and presents one interrupt output to an 8-bit host processor. Requests are captured in a request register, either on a rising edge or as a level. They are filtered by a per-line mask and compared against the lines already in service. The lowest-numbered eligible line wins, but only if it outranks every line currently in service.

The host answers the interrupt with three active-low acknowledge pulses. On the first pulse the controller places a subroutine-call opcode on the data bus. On the second it places the low byte of the service address, and on the third the high byte. The service address is formed from a programmed 16-bit base and the winning line number, with entries 4 or 8 bytes apart.

A small register port sets up the block: chip select, read strobe, write strobe, one address bit and an 8-bit data bus. Through it the host programs the mask, the base, the trigger mode and the entry spacing. It also issues end-of-service commands and reads back status. Every clock edge that sees chip select and write strobe both low performs one write. Reads have no side effects.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `intr` is low, the mask holds 8'hFF (all lines masked), the request and in-service registers are zero, and the block is in edge mode with 4-byte spacing. The base is zero and status reads return the request register.
- R2: Register port encoding for writes with `a0`=0, selected by `din[7:6]`:
  - 00: end-of-service when `din[5]`=1.
  - 01: mode word, with `din[0]`=1 for 8-byte spacing, `din[1]`=1 for level trigger, and `din[2]`=1 to make status reads return the in-service register.
  - 10: the next `a0`=1 write loads the base low byte.
  - 11: the next `a0`=1 write loads the base high byte.
  Any other `a0`=1 write loads the mask. A read with `a0`=1 returns the mask.
- R3: In edge mode, a rising edge on a request input sets its request bit at the next clock edge. The bit stays set until acknowledged. An input that stays high does not request again.
- R4: In level mode, each request bit follows its input at every clock edge, except in the cycle the line is acknowledged. A line still high after its end-of-service therefore requests again.
- R5: A masked line keeps its request bit, but it never raises `intr`.
- R6: Among eligible lines, line 0 has the highest priority and line 7 the lowest.
- R7: `intr` is high only when the best eligible line has a strictly lower number than every line in service. It is low from the first acknowledge pulse until the third.
- R8: The bytes presented on the three acknowledge pulses are 8'hCD, then the service address low byte, then the high byte.
- R9: On the first acknowledge pulse, the winning line's request bit clears and its in-service bit sets. The in-service register changes at no other acknowledge.
- R10: The service address is the base with its low 5 bits (4-byte spacing) or low 6 bits (8-byte spacing) cleared, plus the line number times the spacing.
- R11: An end-of-service command clears only the lowest-numbered set in-service bit.
- R12: An acknowledge sequence that starts with no eligible line supplies line 7's address and leaves the in-service register unchanged.
- R13: A read with `a0`=0 returns the request register, or the in-service register when the mode word selected it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Register port select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data or acknowledge byte to host (zero when idle) |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| intr | output | 1 | Interrupt request to host |
| inta_n | input | 1 | Acknowledge pulse from host, active low |

## Verification
The hardest situation to reach from the ports is nested service. Here a lower-priority line is already in service, further requests arrive both above and below it, and end-of-service must peel the in-service bits in priority order. The bench builds this by serving line 4, then raising lines 6 and 2. It checks that only line 2 interrupts, and confirms each end-of-service through status reads and the `intr` pin. Sweeps over every line, both trigger modes and both spacings cover vector arithmetic with a base whose low bits are deliberately set. Every ordered pair of lines is raised together to cover the priority choice.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
    localparam int NUM_IRQ = 8;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2 * DATA_W;
    localparam logic [DATA_W-1:0] CALL_OPCODE = 8'hCD;
    localparam logic [IDX_W:0]    RANK_NONE   = (IDX_W+1)'(NUM_IRQ);

    typedef enum logic [1:0] {
        CMD_EOI     = 2'b00,
        CMD_MODE    = 2'b01,
        CMD_BASE_LO = 2'b10,
        CMD_BASE_HI = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        TGT_MASK    = 2'd0,
        TGT_BASE_LO = 2'd1,
        TGT_BASE_HI = 2'd2
    } wtgt_e;

    typedef enum logic [1:0] {
        PH_CALL = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

    typedef struct packed {
        logic level;
        logic wide;
        logic stat_isr;
    } mode_t;

    // Rank of the lowest set bit; RANK_NONE when the vector is empty.
    function automatic logic [IDX_W:0] first_set(input logic [NUM_IRQ-1:0] v);
        logic [IDX_W:0] r;
        r = RANK_NONE;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (v[i]) r = (IDX_W+1)'(i);
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [IDX_W-1:0]  idx,
                                                   input logic              wide);
        logic [ADDR_W-1:0] keep;
        int sh;
        sh   = wide ? 3 : 2;
        keep = ~((ADDR_W'(1) << (IDX_W + sh)) - ADDR_W'(1));
        return (base & keep) | (ADDR_W'(idx) << sh);
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        phase_e n;
        case (p)
            PH_CALL: n = PH_LO;
            PH_LO:   n = PH_HI;
            default: n = PH_CALL;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pic_hostregs.sv
`timescale 1ns/1ps
module pic_hostregs
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                a0,
    input  logic [DATA_W-1:0]   din,
    output logic [NUM_IRQ-1:0]  mask,
    output logic [ADDR_W-1:0]   base,
    output mode_t               mode,
    output logic                eoi
);
    logic  wr_en;
    wtgt_e tgt;
    cmd_e  cmd;

    assign wr_en = ~cs_n & ~wr_n;
    assign cmd   = cmd_e'(din[7:6]);
    assign eoi   = wr_en & ~a0 & (cmd == CMD_EOI) & din[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            base <= '0;
            mode <= '0;
            tgt  <= TGT_MASK;
        end else if (wr_en) begin
            if (!a0) begin
                case (cmd)
                    CMD_MODE: begin
                        mode.wide     <= din[0];
                        mode.level    <= din[1];
                        mode.stat_isr <= din[2];
                    end
                    CMD_BASE_LO: tgt <= TGT_BASE_LO;
                    CMD_BASE_HI: tgt <= TGT_BASE_HI;
                    default: ;
                endcase
            end else begin
                case (tgt)
                    TGT_BASE_LO: begin
                        base[DATA_W-1:0] <= din;
                        tgt              <= TGT_MASK;
                    end
                    TGT_BASE_HI: begin
                        base[ADDR_W-1:DATA_W] <= din;
                        tgt                   <= TGT_MASK;
                    end
                    default: mask <= din[NUM_IRQ-1:0];
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_reqcap.sv
`timescale 1ns/1ps
module pic_reqcap
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               level,
    input  logic [NUM_IRQ-1:0] clr,
    output logic [NUM_IRQ-1:0] irr
);
    logic [NUM_IRQ-1:0] prev;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                irr[g]  <= 1'b0;
                prev[g] <= 1'b0;
            end else begin
                prev[g] <= irq_in[g];
                if (clr[g])
                    irr[g] <= 1'b0;
                else if (level)
                    irr[g] <= irq_in[g];
                else if (irq_in[g] && !prev[g])
                    irr[g] <= 1'b1;
            end
        end

        AST_IRR_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
            $rose(irr[g]) |-> $past(irq_in[g])); // R3
    end

    AST_ACK_CLEARS_IRR: assert property (@(posedge clk) disable iff (rst)
        $past(clr) != '0 |-> (irr & $past(clr)) == '0); // R9
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core
    import pic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic               eoi,
    input  logic               inta_n,
    input  logic [ADDR_W-1:0]  base,
    input  logic               wide,
    output logic [NUM_IRQ-1:0] irr_clr,
    output logic [NUM_IRQ-1:0] isr,
    output logic               intr,
    output logic [DATA_W-1:0]  ack_byte,
    output logic               ack_drive
);
    logic [NUM_IRQ-1:0] eligible, isr_n;
    logic [IDX_W:0]     elig_rank, isr_rank;
    logic               pending, inta_q, fall, take;
    phase_e             next_ph, cur_ph;
    logic [IDX_W-1:0]   win_idx;
    logic [ADDR_W-1:0]  vec;

    assign eligible  = irr & ~mask;
    assign elig_rank = first_set(eligible);
    assign isr_rank  = first_set(isr);
    assign pending   = elig_rank < isr_rank;
    assign fall      = inta_q & ~inta_n;
    assign take      = fall && (next_ph == PH_CALL) && pending;
    assign intr      = pending && (next_ph == PH_CALL);
    assign ack_drive = ~inta_q & ~inta_n;

    always_comb begin
        irr_clr = '0;
        if (take) irr_clr[elig_rank[IDX_W-1:0]] = 1'b1;
    end

    always_comb begin
        isr_n = isr;
        if (eoi && isr_rank != RANK_NONE) isr_n[isr_rank[IDX_W-1:0]] = 1'b0;
        if (take) isr_n[elig_rank[IDX_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            inta_q  <= 1'b1;
            next_ph <= PH_CALL;
            cur_ph  <= PH_CALL;
            win_idx <= '0;
        end else begin
            isr    <= isr_n;
            inta_q <= inta_n;
            if (fall) begin
                cur_ph  <= next_ph;
                next_ph <= next_phase(next_ph);
                if (next_ph == PH_CALL)
                    win_idx <= pending ? elig_rank[IDX_W-1:0] : IDX_W'(NUM_IRQ - 1);
            end
        end
    end

    assign vec = vec_addr(base, win_idx, wide);

    always_comb begin
        case (cur_ph)
            PH_CALL: ack_byte = CALL_OPCODE;
            PH_LO:   ack_byte = vec[DATA_W-1:0];
            default: ack_byte = vec[ADDR_W-1:DATA_W];
        endcase
    end

    AST_ISR_SET_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (isr & ~$past(isr)) != '0 |-> $past(fall && next_ph == PH_CALL)); // R9

    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
        $past(eoi) && $past(isr) != '0 && !$past(fall)
            |-> $countones(isr) == $countones($past(isr)) - 1); // R11
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        a0,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    input  logic [7:0]  irq_in,
    output logic        intr,
    input  logic        inta_n
);
    logic [NUM_IRQ-1:0] mask, irr, isr, irr_clr;
    logic [ADDR_W-1:0]  base;
    mode_t              mode;
    logic               eoi, ack_drive, rd_en;
    logic [DATA_W-1:0]  ack_byte;

    pic_hostregs u_regs (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .din(din),
        .mask(mask), .base(base), .mode(mode), .eoi(eoi)
    );

    pic_reqcap u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level(mode.level),
        .clr(irr_clr), .irr(irr)
    );

    pic_core u_core (
        .clk(clk), .rst(rst), .irr(irr), .mask(mask), .eoi(eoi),
        .inta_n(inta_n), .base(base), .wide(mode.wide),
        .irr_clr(irr_clr), .isr(isr), .intr(intr),
        .ack_byte(ack_byte), .ack_drive(ack_drive)
    );

    assign rd_en = ~cs_n & ~rd_n;

    always_comb begin
        if (ack_drive)
            dout = ack_byte;
        else if (rd_en)
            dout = a0 ? mask : (mode.stat_isr ? isr : irr);
        else
            dout = '0;
    end

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        intr |-> (irr & ~mask) != '0); // R5

    AST_SEQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(ack_drive) && ack_drive |-> !intr); // R7
endmodule

// File: tb/test_pic_ctrl.sv
`timescale 1ns/1ps
module test_pic_ctrl;
    logic       clk = 0, rst = 1;
    logic       cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0, inta_n = 1;
    logic [7:0] din = 0, irq_in = 0, dout;
    logic       intr;
    int         n_chk = 0, n_bad = 0;
    logic       m_level = 0, m_wide = 0;

    pic_ctrl i_pic_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
        .din(din), .dout(dout), .irq_in(irq_in), .intr(intr), .inta_n(inta_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; wr_n = 0; a0 = addr; din = d;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic rd(input logic addr, output logic [7:0] d);
        @(negedge clk);
        cs_n = 0; rd_n = 0; a0 = addr;
        #1 d = dout;
        cs_n = 1; rd_n = 1;
    endtask

    task automatic ack(output logic [7:0] d);
        @(negedge clk);
        inta_n = 0;
        @(negedge clk);
        d = dout;
        inta_n = 1;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic lvl, input logic wd, input logic st);
        m_level = lvl; m_wide = wd;
        wr(0, {2'b01, 3'b000, st, lvl, wd});
    endtask

    task automatic set_base(input logic [15:0] b);
        wr(0, 8'h80); wr(1, b[7:0]);
        wr(0, 8'hC0); wr(1, b[15:8]);
    endtask

    task automatic eoi();
        wr(0, 8'h20);
    endtask

    function automatic logic [15:0] expect_vec(input logic [15:0] b, input int idx, input logic wd);
        int sp;
        sp = wd ? 8 : 4;
        return (b - (b % (sp * 8))) + 16'(idx * sp);
    endfunction

    // Full acknowledge sequence with byte checks.
    task automatic serve(input int idx, input logic [15:0] b, input string req);
        logic [7:0] v;
        logic [15:0] e;
        e = expect_vec(b, idx, m_wide);
        ack(v); chk("R8", "call opcode", {8'h0, v}, 16'h00CD);
        chk("R7", "intr low inside sequence", {15'h0, intr}, 16'h0);
        ack(v); chk(req, "vector low byte", {8'h0, v}, {8'h0, e[7:0]});
        ack(v); chk(req, "vector high byte", {8'h0, v}, {8'h0, e[15:8]});
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [15:0] b;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "intr after reset", {15'h0, intr}, 16'h0);
        rd(1, v); chk("R1", "mask after reset", {8'h0, v}, 16'h00FF);
        rd(0, v); chk("R1", "irr after reset", {8'h0, v}, 16'h0000);
        irq_in = 8'h01;
        @(negedge clk); @(negedge clk);
        chk("R1", "all masked after reset", {15'h0, intr}, 16'h0);
        irq_in = 8'h00;
        wr(1, 8'h00);
        rd(1, v); chk("R2", "mask readback", {8'h0, v}, 16'h0000);
        // Leftover edge from IR0 is latched; clear it by serving.
        chk("R5", "unmask releases latched line", {15'h0, intr}, 16'h1);
        serve(0, 16'h0000, "R10");
        eoi();

        // Sweep: both trigger modes, both spacings, every line
        for (int lv = 0; lv < 2; lv++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int idx = 0; idx < 8; idx++) begin
                    b = 16'hA5F7 ^ 16'(idx * 16'h1351);
                    set_mode(lv[0], wd[0], 1'b0);
                    set_base(b);
                    irq_in = 8'(1 << idx);
                    @(negedge clk);
                    chk(lv ? "R4" : "R3", "intr after request", {15'h0, intr}, 16'h1);
                    rd(0, v); chk("R13", "irr status", {8'h0, v}, 16'(1 << idx));
                    serve(idx, b, "R10");
                    set_mode(lv[0], wd[0], 1'b1);
                    rd(0, v); chk("R9", "isr after ack", {8'h0, v}, 16'(1 << idx));
                    set_mode(lv[0], wd[0], 1'b0);
                    rd(0, v);
                    chk(lv ? "R4" : "R3", "irr after ack, input high", {8'h0, v},
                        lv ? 16'(1 << idx) : 16'h0);
                    eoi();
                    chk(lv ? "R4" : "R3", "re-request after eoi", {15'h0, intr}, lv ? 16'h1 : 16'h0);
                    irq_in = 8'h00;
                    @(negedge clk);
                    chk("R4", "intr after input drop", {15'h0, intr}, 16'h0);
                    set_mode(lv[0], wd[0], 1'b1);
                    rd(0, v); chk("R11", "isr after eoi", {8'h0, v}, 16'h0000);
                end
            end
        end

        // Every ordered pair raised together
        set_mode(1'b0, 1'b0, 1'b0);
        set_base(16'h1000);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (i != j) begin
                    int hi_p, lo_p;
                    hi_p = (i < j) ? i : j;
                    lo_p = (i < j) ? j : i;
                    irq_in = 8'(1 << i) | 8'(1 << j);
                    @(negedge clk);
                    serve(hi_p, 16'h1000, "R6");
                    chk("R7", "lower line held while higher in service", {15'h0, intr}, 16'h0);
                    eoi();
                    chk("R7", "lower line after eoi", {15'h0, intr}, 16'h1);
                    serve(lo_p, 16'h1000, "R6");
                    eoi();
                    irq_in = 8'h00;
                    @(negedge clk);
                end
            end
        end

        // Nested service
        set_mode(1'b0, 1'b0, 1'b1);
        irq_in = 8'h10; @(negedge clk);
        serve(4, 16'h1000, "R10");
        irq_in = 8'h50; @(negedge clk);
        chk("R7", "line 6 blocked by line 4", {15'h0, intr}, 16'h0);
        irq_in = 8'h54; @(negedge clk);
        chk("R7", "line 2 preempts line 4", {15'h0, intr}, 16'h1);
        serve(2, 16'h1000, "R6");
        rd(0, v); chk("R9", "nested isr", {8'h0, v}, 16'h0014);
        eoi();
        rd(0, v); chk("R11", "eoi clears line 2 only", {8'h0, v}, 16'h0010);
        chk("R7", "line 6 still blocked", {15'h0, intr}, 16'h0);
        eoi();
        chk("R7", "line 6 after both eoi", {15'h0, intr}, 16'h1);
        serve(6, 16'h1000, "R10");
        eoi();
        irq_in = 8'h00; @(negedge clk);

        // Masking each line
        set_mode(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            wr(1, 8'(1 << k));
            irq_in = 8'(1 << k); @(negedge clk);
            chk("R5", "masked line silent", {15'h0, intr}, 16'h0);
            rd(0, v); chk("R5", "masked line kept in irr", {8'h0, v}, 16'(1 << k));
            rd(1, v); chk("R2", "mask readback", {8'h0, v}, 16'(1 << k));
            wr(1, 8'h00);
            chk("R5", "unmasked line raises intr", {15'h0, intr}, 16'h1);
            serve(k, 16'h1000, "R10");
            eoi();
            irq_in = 8'h00; @(negedge clk);
        end

        // Spurious acknowledge
        set_mode(1'b0, 1'b1, 1'b1);
        set_base(16'h2345);
        chk("R12", "idle intr", {15'h0, intr}, 16'h0);
        serve(7, 16'h2345, "R12");
        rd(0, v); chk("R12", "isr unchanged", {8'h0, v}, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule